// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a small three-wire serial EEPROM. The host places a word address on the address input, chooses narrow (6-bit) or wide (8-bit) addressing to suit the size of the attached device, and pulses the start input. The block then drives the device's select, clock and serial-input lines through one complete read frame. It assembles the 16 bits that the device returns and presents the word together with a one-cycle completion pulse.

Each frame has a fixed order. It opens with one dummy clock while the device is selected, then sends the 3-bit read command and then the address, both most significant bit first. Sixteen data clocks follow, and the frame ends with one clock while the device is deselected. Each half of the serial clock lasts a parameterised number of system clocks, so the device's setup and hold times can be met at any system frequency. Only reads are issued.

Top module: `sprom_word_reader`

## Requirements
- R1: After an accepted start, the first slot of the frame has select high, serial input 0 and one clock pulse (low half, then high half) before any command bit.
- R2: The command sent after the lead-in slot is the 3-bit value 110 (binary), most significant bit first.
- R3: The address follows the command, most significant bit first, using rd_addr_i[5:0] when wide_addr_i is 0 and rd_addr_i[7:0] when it is 1. Address bits above the selected width have no effect on the result.
- R4: Every serial-clock half lasts exactly HALF_CLKS system clocks. The serial input changes only while the serial clock is low, and it is stable across each rising edge.
- R5: The serial input is 0 in every slot except the command and address slots.
- R6: Exactly 16 data slots follow the address. In each one the device output is sampled in the last system clock of the high half, and the bits are assembled most significant first into rd_data_o.
- R7: After the last data slot, select goes low with the clock low. One more full clock pulse follows while the device is deselected, and then one closing low half ends the frame.
- R8: A start pulse that arrives while busy_o is high is ignored. Address and width are captured at the accepted start, and later changes to them have no effect on the frame in progress.
- R9: busy_o rises in the cycle after an accepted start and stays high until the completion cycle. In that cycle done_o is high for one cycle and busy_o is low. A start in the completion cycle is accepted.
- R10: rd_data_o changes only in the completion cycle and holds its value at all other times.
- R11: During and after reset, all outputs are 0 until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| rd_start_i | input | 1 | Start a word read (one-cycle pulse) |
| wide_addr_i | input | 1 | 0 selects 6-bit addressing, 1 selects 8-bit addressing |
| rd_addr_i | input | ADDR_W_WIDE | Word address |
| busy_o | output | 1 | A read frame is in progress |
| done_o | output | 1 | One-cycle pulse when rd_data_o has been updated |
| rd_data_o | output | 16 | Last word read |
| ee_cs_o | output | 1 | Device select |
| ee_sk_o | output | 1 | Device serial clock |
| ee_di_o | output | 1 | Serial data to the device |
| ee_do_i | input | 1 | Serial data from the device |

## Verification
Counting from the clock edge that accepts a start, busy_o and the frame's first slot are visible one cycle later. Each serial phase then occupies HALF_CLKS cycles, and done_o with the new word arrives (2·(21+address width)+1)·HALF_CLKS cycles after that first cycle. The bench's reference model follows this count with an integer cycle index and derives the expected select, clock, serial input, busy, done and data for every cycle from it. It compares all of them at the falling system-clock edge, half a period after the registers update. A behavioural device model on the serial lines decodes the lead-in, command and address it receives, and it returns the data bit for each slot on the falling serial clock, so the word assembled by the design is checked against the word the device sent.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned CMD_W    = 3;
    localparam logic [CMD_W-1:0] READ_CMD = 3'b110;

    // levels driven onto the three device lines
    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pin_set_t;

endpackage

// File: rtl/sprom_bit_timer.sv
module sprom_bit_timer #(
    parameter int unsigned HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == CNT_W'(HALF_CLKS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sprom_frame_seq.sv
module sprom_frame_seq
    import sprom_pkg::*;
#(
    parameter int unsigned ADDR_W_NARROW = 6,
    parameter int unsigned ADDR_W_WIDE   = 8,
    parameter int unsigned PH_W          = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   wide_i,
    input  logic [ADDR_W_WIDE-1:0] addr_i,
    input  logic                   tick_i,
    output logic                   run_o,
    output pin_set_t               pins_o,
    output logic                   sample_o,
    output logic                   commit_o,
    output logic                   done_o
);
    typedef struct packed {
        logic                   active;
        logic [PH_W-1:0]        phase;
        logic                   wide;
        logic [ADDR_W_WIDE-1:0] addr;
        pin_set_t               pins;
        logic                   done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    function automatic int unsigned addr_width(input logic wd);
        return wd ? ADDR_W_WIDE : ADDR_W_NARROW;
    endfunction

    // lead-in + command + address + data + trailing slot
    function automatic int unsigned slot_count(input logic wd);
        return 1 + CMD_W + addr_width(wd) + WORD_W + 1;
    endfunction

    function automatic logic is_data_slot(input int unsigned slot, input logic wd);
        int unsigned first;
        first = 1 + CMD_W + addr_width(wd);
        return (slot >= first) && (slot < first + WORD_W);
    endfunction

    function automatic pin_set_t pins_for(input logic [PH_W-1:0] ph,
                                          input logic wd,
                                          input logic [ADDR_W_WIDE-1:0] ad);
        int unsigned phi, slot, aw, nsl;
        logic [CMD_W-1:0]       cmd_sh;
        logic [ADDR_W_WIDE-1:0] adr_sh;
        pin_set_t p;
        phi    = 32'(ph);
        slot   = phi >> 1;
        aw     = addr_width(wd);
        nsl    = slot_count(wd);
        p.sk   = ph[0];
        p.cs   = (slot < nsl - 1);
        p.di   = 1'b0;
        cmd_sh = '0;
        adr_sh = '0;
        if (slot >= 1 && slot <= CMD_W) begin
            cmd_sh = READ_CMD >> (CMD_W - slot);
            p.di   = cmd_sh[0];
        end else if (slot > CMD_W && slot <= CMD_W + aw) begin
            adr_sh = ad >> (aw - (slot - CMD_W));
            p.di   = adr_sh[0];
        end
        return p;
    endfunction

    logic final_phase;
    logic high_data;

    assign final_phase = (32'(st_q.phase) == 2 * slot_count(st_q.wide));
    assign high_data   = st_q.phase[0] && is_data_slot(32'(st_q.phase) >> 1, st_q.wide);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sample_o  = 1'b0;
        commit_o  = 1'b0;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.phase  = '0;
                st_d.wide   = wide_i;
                st_d.addr   = addr_i;
                st_d.pins   = pins_for('0, wide_i, addr_i);
            end
        end else if (tick_i) begin
            if (final_phase) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
                st_d.pins   = '0;
                commit_o    = 1'b1;
            end else begin
                sample_o   = high_data;
                st_d.phase = st_q.phase + 1'b1;
                st_d.pins  = pins_for(st_q.phase + 1'b1, st_q.wide, st_q.addr);
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.active;
    assign pins_o = st_q.pins;
    assign done_o = st_q.done;
endmodule

// File: rtl/sprom_rx_shift.sv
module sprom_rx_shift #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic             serial_i,
    input  logic             commit_i,
    output logic [WIDTH-1:0] word_o
);
    typedef struct packed {
        logic [WIDTH-1:0] shreg;
        logic [WIDTH-1:0] word;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (sample_i) begin
            rx_d.shreg = {rx_q.shreg[WIDTH-2:0], serial_i};
        end
        if (commit_i) begin
            rx_d.word = rx_q.shreg;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign word_o = rx_q.word;
endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
    import sprom_pkg::*;
#(
    parameter int unsigned HALF_CLKS     = 2,
    parameter int unsigned ADDR_W_NARROW = 6,
    parameter int unsigned ADDR_W_WIDE   = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_start_i,
    input  logic                   wide_addr_i,
    input  logic [ADDR_W_WIDE-1:0] rd_addr_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [WORD_W-1:0]      rd_data_o,
    output logic                   ee_cs_o,
    output logic                   ee_sk_o,
    output logic                   ee_di_o,
    input  logic                   ee_do_i
);
    localparam int unsigned SLOTS_MAX = 1 + CMD_W + ADDR_W_WIDE + WORD_W + 1;
    localparam int unsigned PH_W      = $clog2(2 * SLOTS_MAX + 1);

    logic     run, tick, sample, commit;
    pin_set_t pins;

    sprom_bit_timer #(
        .HALF_CLKS (HALF_CLKS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    sprom_frame_seq #(
        .ADDR_W_NARROW (ADDR_W_NARROW),
        .ADDR_W_WIDE   (ADDR_W_WIDE),
        .PH_W          (PH_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (rd_start_i),
        .wide_i   (wide_addr_i),
        .addr_i   (rd_addr_i),
        .tick_i   (tick),
        .run_o    (run),
        .pins_o   (pins),
        .sample_o (sample),
        .commit_o (commit),
        .done_o   (done_o)
    );

    sprom_rx_shift #(
        .WIDTH (WORD_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample),
        .serial_i (ee_do_i),
        .commit_i (commit),
        .word_o   (rd_data_o)
    );

    assign busy_o  = run;
    assign ee_cs_o = pins.cs;
    assign ee_sk_o = pins.sk;
    assign ee_di_o = pins.di;
endmodule

// File: rtl/sprom_word_reader_chk.sv
module sprom_word_reader_chk
    import sprom_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              cs,
    input logic              sk,
    input logic              di,
    input logic [WORD_W-1:0] data
);
    // R11: lines stay quiet whenever no frame is running
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cs && !sk && !di));

    // R9: completion pulse only at the end of a busy stretch
    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8: a frame begins only from idle and only on a start request
    assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) && !$past(busy)));

    // R4: serial input settled before the clock rises
    assert_di_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sk) |-> $stable(di));

    // R4: serial input moves only while the clock is low
    assert_di_moves_low_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(di) |-> !sk);

    // R7: deselect happens with the clock low
    assert_deselect_clock_low_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cs) |-> !sk);

    // R10: result changes only with the completion pulse
    assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(data) |-> done);
endmodule

bind sprom_word_reader sprom_word_reader_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (rd_start_i),
    .busy  (busy_o),
    .done  (done_o),
    .cs    (ee_cs_o),
    .sk    (ee_sk_o),
    .di    (ee_di_o),
    .data  (rd_data_o)
);

// File: tb/sim_sprom_word_reader.sv
module sim_sprom_word_reader;
    // time unit is the default 1 ps; 2500 ps half period gives 200 MHz
    localparam int CLK_HALF_PS = 2500;
    localparam int HALF        = 3;
    localparam int WATCHDOG    = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        busy_o, done_o, ee_cs_o, ee_sk_o, ee_di_o;
    logic [15:0] rd_data_o;
    logic        dev_do = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit chk_en = 1'b0;

    always #CLK_HALF_PS clk = ~clk;

    sprom_word_reader #(
        .HALF_CLKS     (HALF),
        .ADDR_W_NARROW (6),
        .ADDR_W_WIDE   (8)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .rd_start_i  (start),
        .wide_addr_i (wide),
        .rd_addr_i   (addr),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rd_data_o   (rd_data_o),
        .ee_cs_o     (ee_cs_o),
        .ee_sk_o     (ee_sk_o),
        .ee_di_o     (ee_di_o),
        .ee_do_i     (dev_do)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rom_word(input logic [7:0] a);
        logic [7:0] lo;
        lo = 8'(a * 7 + 3);
        if (a == 8'h00) return 16'hFFFF;
        if (a == 8'h01) return 16'h0000;
        return {a ^ 8'hA5, lo};
    endfunction

    function automatic int aw_of(input logic w);
        return w ? 8 : 6;
    endfunction

    function automatic int last_k(input logic w);
        return (2 * (21 + aw_of(w)) + 1) * HALF;
    endfunction

    // ---------------- cycle reference model ----------------
    int          mk = -1;
    logic [7:0]  m_addr = '0;
    logic        m_wide = 1'b0;
    logic [15:0] m_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            mk     <= -1;
            m_data <= '0;
        end else if (mk < 0 || mk == last_k(m_wide)) begin
            if (start) begin
                mk     <= 0;
                m_addr <= addr;
                m_wide <= wide;
            end else begin
                mk <= -1;
            end
        end else begin
            mk <= mk + 1;
            if (mk + 1 == last_k(m_wide))
                m_data <= rom_word(m_wide ? m_addr : {2'b00, m_addr[5:0]});
        end
    end

    always @(negedge clk) begin
        if (!rst && chk_en) begin
            int p, s, aw, n;
            logic e_cs, e_sk, e_di, e_busy, e_done;
            logic [7:0] sh;
            e_cs = 0; e_sk = 0; e_di = 0; e_busy = 0; e_done = 0;
            aw = aw_of(m_wide);
            n  = 21 + aw;
            if (mk >= 0 && mk < last_k(m_wide)) begin
                e_busy = 1;
                p = mk / HALF;
                s = p / 2;
                if (p < 2 * n) begin
                    e_sk = p % 2;
                    e_cs = (s < n - 1);
                    if (s >= 1 && s <= 3) begin
                        sh   = 8'(3'b110 >> (3 - s));
                        e_di = sh[0];
                    end else if (s >= 4 && s <= 3 + aw) begin
                        sh   = m_addr >> (aw - 1 - (s - 4));
                        e_di = sh[0];
                    end
                end
            end else if (mk >= 0 && mk == last_k(m_wide)) begin
                e_done = 1;
            end
            chk("R7 R1 select level", ee_cs_o, e_cs);
            chk("R4 serial clock level", ee_sk_o, e_sk);
            chk("R5 R3 serial input level", ee_di_o, e_di);
            chk("R9 busy", busy_o, e_busy);
            chk("R9 done", done_o, e_done);
            chk("R10 result word", rd_data_o, m_data);
        end
    end

    // ---------------- behavioural serial EEPROM ----------------
    logic [7:0]  tb_addr = '0;
    logic        tb_wide = 1'b0;
    int          dev_rise = 0;
    int          dev_fall = 0;
    logic [31:0] dev_bits = '0;
    logic [15:0] dev_word = '0;

    always @(posedge ee_cs_o) begin
        dev_rise = 0;
        dev_fall = 0;
        dev_bits = '0;
        dev_do   = 1'b0;
    end

    always @(posedge ee_sk_o) begin
        if (ee_cs_o) begin
            dev_bits = {dev_bits[30:0], ee_di_o};
            dev_rise++;
        end
    end

    always @(negedge ee_sk_o) begin
        if (ee_cs_o) begin
            int aw;
            logic [7:0] got_addr, exp_addr;
            aw = aw_of(tb_wide);
            dev_fall++;
            if (dev_fall == 4 + aw) begin
                got_addr = 8'(dev_bits & ((32'd1 << aw) - 1));
                exp_addr = tb_wide ? tb_addr : {2'b00, tb_addr[5:0]};
                chk("R1 lead-in bit", (dev_bits >> (aw + 3)) & 32'd1, 0);
                chk("R2 read command", (dev_bits >> aw) & 32'd7, 32'd6);
                chk("R3 received address", got_addr, exp_addr);
                dev_word = rom_word(got_addr);
                dev_do   = dev_word[15];
            end else if (dev_fall > 4 + aw && dev_fall < 20 + aw) begin
                dev_do = dev_word[15 - (dev_fall - 4 - aw)];
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_read(input logic [7:0] a, input logic w);
        tb_addr = a;
        tb_wide = w;
        @(negedge clk);
        start = 1'b1;
        addr  = a;
        wide  = w;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", busy_o, 1);
        while (!done_o) @(negedge clk);
        chk("R6 assembled word", rd_data_o, rom_word(w ? a : {2'b00, a[5:0]}));
        chk("R9 busy low at done", busy_o, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R9 actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 select in reset", ee_cs_o, 0);
        chk("R11 clock in reset", ee_sk_o, 0);
        chk("R11 data in reset", ee_di_o, 0);
        chk("R11 busy in reset", busy_o, 0);
        chk("R11 done in reset", done_o, 0);
        chk("R11 word in reset", rd_data_o, 0);
        rst = 1'b0;
        chk_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 idle after reset", {busy_o, ee_cs_o, ee_sk_o}, 0);

        // narrow and wide reads, R3 upper bits ignored in narrow mode
        run_read(8'h2D, 1'b0);
        run_read(8'hC3, 1'b1);
        run_read(8'hC3, 1'b0);
        run_read(8'h00, 1'b1);
        run_read(8'h01, 1'b1);
        run_read(8'hFF, 1'b0);

        // R8: start and input changes while busy are ignored
        tb_addr = 8'h15;
        tb_wide = 1'b0;
        @(negedge clk);
        start = 1'b1; addr = 8'h15; wide = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; addr = 8'hEE; wide = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 still busy after ignored start", busy_o, 1);
        while (!done_o) @(negedge clk);
        chk("R8 word of captured address", rd_data_o, rom_word(8'h15));

        // R10: result held while idle and inputs move
        held = rd_data_o;
        repeat (30) begin
            @(negedge clk);
            addr = addr + 8'd3;
            wide = ~wide;
        end
        chk("R10 word held while idle", rd_data_o, held);

        // R9: start held high, second read accepted in the completion cycle
        tb_addr = 8'h7A;
        tb_wide = 1'b1;
        @(negedge clk);
        start = 1'b1; addr = 8'h7A; wide = 1'b1;
        while (!done_o) @(negedge clk);
        chk("R9 first back-to-back word", rd_data_o, rom_word(8'h7A));
        @(negedge clk);
        chk("R9 restart in completion cycle", busy_o, 1);
        start = 1'b0;
        while (!done_o) @(negedge clk);
        chk("R9 second back-to-back word", rd_data_o, rom_word(8'h7A));
        repeat (5) @(negedge clk);
        chk("R9 idle after frames", busy_o, 0);

        finish_run();
    end
endmodule